// File: doc/BRIEF.md
# Saturating Integer Arithmetic Unit

This unit computes one clamped integer result per accepted operation. It covers signed and unsigned addition and subtraction, absolute value and negation with a clamp on the most negative value, narrowing of a 64-bit value to an element of 8, 16, 32 or 64 bits under any pairing of signed or unsigned source with signed or unsigned destination, and two mixed-sign accumulations: an unsigned value plus a signed value giving a signed result, and a signed value plus an unsigned value giving an unsigned result.

Whenever an operation has to clamp its result, a sticky saturation flag is raised. The flag stays high across later operations that do not clamp, until the surrounding logic pulses an explicit clear. Each result is registered, so it appears with its valid bit one clock after the operands are presented. Addition, subtraction, unary and accumulate operations always work on the full 64-bit operand. The element-size code only affects narrowing.

Top module: `sat_alu`

## Requirements
- R1: The narrowing element width is 8 << elem_size (code 0 = 8, 1 = 16, 2 = 32, 3 = 64 bits). A 64-bit narrowing with a signed source and a signed destination never clamps.
- R2: Narrowing opcodes: 6 = signed to signed, clamped to [-(2^(w-1)), 2^(w-1)-1]. 7 = signed to unsigned, clamped to [0, 2^w-1]. 8 = unsigned to signed, clamped to at most 2^(w-1)-1. 9 = unsigned to unsigned, clamped to at most 2^w-1. A signed result is sign-extended to 64 bits and an unsigned result is zero-extended.
- R3: Opcode 0 (signed add) returns a+b. On signed overflow it returns 0x8000_0000_0000_0000 if a is negative, otherwise 0x7FFF_FFFF_FFFF_FFFF, and it saturates.
- R4: Opcode 2 (signed subtract) returns a-b. On signed overflow it clamps by the sign of a, using the same two limits as R3, and it saturates.
- R5: Opcode 1 (unsigned add) returns all ones and saturates on carry out. Opcode 3 (unsigned subtract) returns 0 and saturates when a < b.
- R6: Opcode 4 returns |a| and opcode 5 returns -a. Both return 0x7FFF_FFFF_FFFF_FFFF and saturate when a is 0x8000_0000_0000_0000.
- R7: Opcode 10 adds an unsigned a to a signed b and gives a signed result, clamped to 0x7FFF_FFFF_FFFF_FFFF on positive overflow.
- R8: Opcode 11 adds a signed a to an unsigned b and gives an unsigned result. It is clamped to all ones on overflow and to 0 when the true sum is negative.
- R9: sat_flag rises one cycle after any accepted clamping operation. It stays set through later operations that do not clamp.
- R10: sat_clr clears sat_flag on the next edge. When a clear and a clamping operation arrive in the same cycle, the flag ends set.
- R11: out_valid follows in_valid one cycle later, and out_result carries that cycle's result. While in_valid is low, out_result holds its value and sat_flag is not set.
- R12: After reset, out_valid is 0, out_result is 0 and sat_flag is 0.
- R13: Opcodes 12 to 15 return 0 and never set sat_flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Operation accepted this cycle |
| op | input | 4 | Operation code (see requirements) |
| elem_size | input | 2 | Narrowing element size code |
| opa | input | 64 | First operand |
| opb | input | 64 | Second operand |
| sat_clr | input | 1 | Clear strobe for the saturation flag |
| out_valid | output | 1 | Result valid |
| out_result | output | 64 | Registered result |
| sat_flag | output | 1 | Sticky saturation flag |

## Verification
The clear strobe and a clamping operation can land in the same cycle. The table walk drives sat_clr high alongside every vector, so every clamping vector tests "set wins" and every non-clamping vector tests a plain clear. After each one the bench checks that the flag equals that vector's own saturation outcome. Directed steps then separate the two actions: a clear with no operation, and a clamping operation followed by a non-clamping one with no clear. These show that each action alone behaves as required.

// File: rtl/sat_alu_pkg.sv
// Package: shared operation codes for the saturating arithmetic unit.
// Assumes a 4-bit opcode; codes 12..15 are unassigned and yield zero.
package sat_alu_pkg;

    typedef enum logic [3:0] {
        OP_SADD = 4'd0,
        OP_UADD = 4'd1,
        OP_SSUB = 4'd2,
        OP_USUB = 4'd3,
        OP_SABS = 4'd4,
        OP_SNEG = 4'd5,
        OP_NSS  = 4'd6,
        OP_NSU  = 4'd7,
        OP_NUS  = 4'd8,
        OP_NUU  = 4'd9,
        OP_SACC = 4'd10,
        OP_UACC = 4'd11
    } sat_op_e;

endpackage

// File: rtl/sat_addsub.sv
// Module: sat_addsub
// Combinational add/subtract/accumulate with clamping on DATA_W-bit words.
// Assumes operands are full-width; produces zero and no saturation for
// opcodes it does not own.
module sat_addsub
    import sat_alu_pkg::*;
#(
    parameter int DATA_W = 64
) (
    input  sat_op_e             op,
    input  logic [DATA_W-1:0]   a,
    input  logic [DATA_W-1:0]   b,
    output logic [DATA_W-1:0]   res,
    output logic                sat
);

    localparam int MSB = DATA_W - 1;
    localparam logic [DATA_W-1:0] SMAX = {1'b0, {(DATA_W-1){1'b1}}};
    localparam logic [DATA_W-1:0] SMIN = {1'b1, {(DATA_W-1){1'b0}}};
    localparam logic [DATA_W-1:0] UMAX = {DATA_W{1'b1}};

    logic [DATA_W:0]   sum_c;
    logic [DATA_W-1:0] sum;
    logic              carry;
    logic [DATA_W-1:0] diff;
    logic              borrow;
    logic              add_sovf;
    logic              sub_sovf;

    // Shared adder and subtractor with carry/borrow extraction.
    always_comb begin
        sum_c  = {1'b0, a} + {1'b0, b};
        sum    = sum_c[DATA_W-1:0];
        carry  = sum_c[DATA_W];
        diff   = a - b;
        borrow = (a < b);
    end

    // Signed overflow detection from operand and result sign bits.
    always_comb begin
        add_sovf = ~(a[MSB] ^ b[MSB]) & (a[MSB] ^ sum[MSB]);
        sub_sovf =  (a[MSB] ^ b[MSB]) & (a[MSB] ^ diff[MSB]);
    end

    // Per-operation result selection and clamping.
    always_comb begin
        res = '0;
        sat = 1'b0;
        case (op)
            OP_SADD: begin
                if (add_sovf) begin
                    res = a[MSB] ? SMIN : SMAX;
                    sat = 1'b1;
                end else begin
                    res = sum;
                end
            end
            OP_SSUB: begin
                if (sub_sovf) begin
                    res = a[MSB] ? SMIN : SMAX;
                    sat = 1'b1;
                end else begin
                    res = diff;
                end
            end
            OP_UADD: begin
                if (carry) begin
                    res = UMAX;
                    sat = 1'b1;
                end else begin
                    res = sum;
                end
            end
            OP_USUB: begin
                if (borrow) begin
                    res = '0;
                    sat = 1'b1;
                end else begin
                    res = diff;
                end
            end
            OP_SACC: begin
                // unsigned a + signed b -> signed result
                if (!a[MSB]) begin
                    if (!b[MSB] && sum[MSB]) begin
                        res = SMAX;
                        sat = 1'b1;
                    end else begin
                        res = sum;
                    end
                end else if (!b[MSB]) begin
                    res = SMAX;
                    sat = 1'b1;
                end else if (sum[MSB]) begin
                    res = SMAX;
                    sat = 1'b1;
                end else begin
                    res = sum;
                end
            end
            OP_UACC: begin
                // signed a + unsigned b -> unsigned result
                if (!a[MSB]) begin
                    if (carry) begin
                        res = UMAX;
                        sat = 1'b1;
                    end else begin
                        res = sum;
                    end
                end else if (b[MSB]) begin
                    res = sum;
                end else if (sum[MSB]) begin
                    res = '0;
                    sat = 1'b1;
                end else begin
                    res = sum;
                end
            end
            default: begin
                res = '0;
                sat = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/sat_unary.sv
// Module: sat_unary
// Absolute value and negation with a clamp on the most negative value.
// Assumes two's complement DATA_W-bit input; non-owned opcodes give zero.
module sat_unary
    import sat_alu_pkg::*;
#(
    parameter int DATA_W = 64
) (
    input  sat_op_e             op,
    input  logic [DATA_W-1:0]   a,
    output logic [DATA_W-1:0]   res,
    output logic                sat
);

    localparam int MSB = DATA_W - 1;
    localparam logic [DATA_W-1:0] SMAX = {1'b0, {(DATA_W-1){1'b1}}};
    localparam logic [DATA_W-1:0] SMIN = {1'b1, {(DATA_W-1){1'b0}}};

    logic              is_min;
    logic [DATA_W-1:0] neg_a;

    // Detect the unrepresentable magnitude and form the negation.
    always_comb begin
        is_min = (a == SMIN);
        neg_a  = '0 - a;
    end

    // Select absolute value or negation, clamping the minimum.
    always_comb begin
        res = '0;
        sat = 1'b0;
        if (op == OP_SABS || op == OP_SNEG) begin
            if (is_min) begin
                res = SMAX;
                sat = 1'b1;
            end else if (op == OP_SNEG) begin
                res = neg_a;
            end else begin
                res = a[MSB] ? neg_a : a;
            end
        end
    end

endmodule

// File: rtl/sat_narrow.sv
// Module: sat_narrow
// Clamps a DATA_W-bit value into an element of 8 << size bits, with
// signed or unsigned source and destination picked by the opcode.
// Assumes the widest element (8 << (2^SIZE_W - 1)) does not exceed DATA_W.
module sat_narrow
    import sat_alu_pkg::*;
#(
    parameter int DATA_W = 64,
    parameter int SIZE_W = 2
) (
    input  sat_op_e             op,
    input  logic [SIZE_W-1:0]   size,
    input  logic [DATA_W-1:0]   a,
    output logic [DATA_W-1:0]   res,
    output logic                sat
);

    localparam int NUM_SIZES = 1 << SIZE_W;
    localparam int EXT_W     = DATA_W + 2;

    logic signed [EXT_W-1:0] hi_s [NUM_SIZES];
    logic signed [EXT_W-1:0] lo_s [NUM_SIZES];
    logic signed [EXT_W-1:0] hi_u [NUM_SIZES];

    // Limit table: one signed/unsigned bound set per element-size code.
    for (genvar g = 0; g < NUM_SIZES; g++) begin : g_lim
        localparam int EW = 8 << g;
        assign hi_s[g] = (EXT_W'(1) << (EW - 1)) - EXT_W'(1);
        assign lo_s[g] = EXT_W'(0) - (EXT_W'(1) << (EW - 1));
        assign hi_u[g] = (EXT_W'(1) << EW) - EXT_W'(1);
    end

    logic                    owned;
    logic                    src_signed;
    logic                    dst_signed;
    logic signed [EXT_W-1:0] src_ext;
    logic signed [EXT_W-1:0] hi;
    logic signed [EXT_W-1:0] lo;
    logic signed [EXT_W-1:0] clamped;
    logic                    unused_hi;

    // Decode source/destination signedness from the opcode.
    always_comb begin
        owned      = (op == OP_NSS) || (op == OP_NSU) ||
                     (op == OP_NUS) || (op == OP_NUU);
        src_signed = (op == OP_NSS) || (op == OP_NSU);
        dst_signed = (op == OP_NSS) || (op == OP_NUS);
    end

    // Extend the source and pick the bounds for this element size.
    always_comb begin
        src_ext = src_signed ? {{2{a[DATA_W-1]}}, a} : {2'b00, a};
        hi      = dst_signed ? hi_s[size] : hi_u[size];
        lo      = dst_signed ? lo_s[size] : '0;
    end

    // Clamp against the bounds and report saturation.
    always_comb begin
        clamped = src_ext;
        sat     = 1'b0;
        if (owned) begin
            if (src_ext > hi) begin
                clamped = hi;
                sat     = 1'b1;
            end else if (src_ext < lo) begin
                clamped = lo;
                sat     = 1'b1;
            end
        end
        res       = owned ? clamped[DATA_W-1:0] : '0;
        unused_hi = ^clamped[EXT_W-1:DATA_W];
    end

endmodule

// File: rtl/sat_sticky.sv
// Module: sat_sticky
// Cumulative saturation flag: set by any reported clamp, cleared only by
// an explicit strobe; a set in the same cycle as a clear wins.
module sat_sticky (
    input  logic clk,
    input  logic rst_n,
    input  logic set_i,
    input  logic clr_i,
    output logic flag_o
);

    // Flag register with set-over-clear priority.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flag_o <= 1'b0;
        end else if (set_i) begin
            flag_o <= 1'b1;
        end else if (clr_i) begin
            flag_o <= 1'b0;
        end
    end

    // R9: the flag is not lost without a clear
    a_r9_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_o && !clr_i) |=> flag_o);

    // R10: a clear with no concurrent clamp empties the flag
    a_r10_clear_only: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_i && !set_i) |=> !flag_o);

    // R10: a clamp always leaves the flag set, clear or not
    a_r10_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
        set_i |=> flag_o);

endmodule

// File: rtl/sat_alu.sv
// Module: sat_alu (top)
// Saturating integer unit: dispatches one operation per valid cycle to the
// add/sub, unary and narrowing datapaths, registers the result with one
// cycle of latency, and maintains a sticky saturation flag.
// Assumes DATA_W = 64 with a 2-bit element-size code for full coverage.
module sat_alu
    import sat_alu_pkg::*;
#(
    parameter int DATA_W = 64,
    parameter int SIZE_W = 2,
    parameter int OP_W   = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [OP_W-1:0]   op,
    input  logic [SIZE_W-1:0] elem_size,
    input  logic [DATA_W-1:0] opa,
    input  logic [DATA_W-1:0] opb,
    input  logic              sat_clr,
    output logic              out_valid,
    output logic [DATA_W-1:0] out_result,
    output logic              sat_flag
);

    sat_op_e           op_e;
    logic [DATA_W-1:0] as_res;
    logic              as_sat;
    logic [DATA_W-1:0] un_res;
    logic              un_sat;
    logic [DATA_W-1:0] nw_res;
    logic              nw_sat;
    logic [DATA_W-1:0] sel_res;
    logic              sel_sat;
    logic              op_known;

    assign op_e = sat_op_e'(op);

    sat_addsub #(.DATA_W(DATA_W)) u_addsub (
        .op  (op_e),
        .a   (opa),
        .b   (opb),
        .res (as_res),
        .sat (as_sat)
    );

    sat_unary #(.DATA_W(DATA_W)) u_unary (
        .op  (op_e),
        .a   (opa),
        .res (un_res),
        .sat (un_sat)
    );

    sat_narrow #(.DATA_W(DATA_W), .SIZE_W(SIZE_W)) u_narrow (
        .op   (op_e),
        .size (elem_size),
        .a    (opa),
        .res  (nw_res),
        .sat  (nw_sat)
    );

    // Route the owning datapath's result and clamp indication.
    always_comb begin
        sel_res  = '0;
        sel_sat  = 1'b0;
        op_known = 1'b1;
        case (op_e)
            OP_SADD, OP_UADD, OP_SSUB, OP_USUB, OP_SACC, OP_UACC: begin
                sel_res = as_res;
                sel_sat = as_sat;
            end
            OP_SABS, OP_SNEG: begin
                sel_res = un_res;
                sel_sat = un_sat;
            end
            OP_NSS, OP_NSU, OP_NUS, OP_NUU: begin
                sel_res = nw_res;
                sel_sat = nw_sat;
            end
            default: begin
                op_known = 1'b0;
            end
        endcase
    end

    // Result register: one cycle latency, holds while idle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid  <= 1'b0;
            out_result <= '0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) begin
                out_result <= sel_res;
            end
        end
    end

    sat_sticky u_sticky (
        .clk    (clk),
        .rst_n  (rst_n),
        .set_i  (in_valid && sel_sat),
        .clr_i  (sat_clr),
        .flag_o (sat_flag)
    );

    // R11: valid is delayed by exactly one cycle
    a_r11_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);
    a_r11_idle_follows: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);

    // R11: result holds while no operation is accepted
    a_r11_hold_result: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> $stable(out_result));

    // R6: an absolute value never comes out negative
    a_r6_abs_nonneg: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && op_e == OP_SABS) |=> !out_result[DATA_W-1]);

    // R5: unsigned underflow yields zero and raises the flag
    a_r5_usub_floor: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && op_e == OP_USUB && (opa < opb)) |=>
        (out_result == '0) && sat_flag);

    // R13: unassigned opcodes produce zero
    a_r13_unknown_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !op_known) |=> (out_result == '0));

endmodule

// File: tb/sat_alu_tb.sv
module sat_alu_tb;

    typedef struct packed {
        logic [3:0]  op;
        logic [1:0]  size;
        logic [63:0] a;
        logic [63:0] b;
        logic [63:0] exp;
        logic        sat;
        logic [3:0]  req;
    } vec_t;

    localparam logic [63:0] SMAX = 64'h7FFF_FFFF_FFFF_FFFF;
    localparam logic [63:0] SMIN = 64'h8000_0000_0000_0000;
    localparam logic [63:0] ONES = 64'hFFFF_FFFF_FFFF_FFFF;
    localparam int NVEC = 35;

    localparam vec_t VECS [NVEC] = '{
        '{4'd0,  2'd0, 64'd5, 64'd7, 64'd12, 1'b0, 4'd3},                       // R3
        '{4'd0,  2'd0, SMAX, 64'd1, SMAX, 1'b1, 4'd3},                          // R3
        '{4'd0,  2'd0, SMIN, ONES, SMIN, 1'b1, 4'd3},                           // R3
        '{4'd2,  2'd0, SMIN, 64'd1, SMIN, 1'b1, 4'd4},                          // R4
        '{4'd2,  2'd0, SMAX, ONES, SMAX, 1'b1, 4'd4},                           // R4
        '{4'd2,  2'd0, 64'd10, 64'd3, 64'd7, 1'b0, 4'd4},                       // R4
        '{4'd1,  2'd0, ONES, 64'd1, ONES, 1'b1, 4'd5},                          // R5
        '{4'd1,  2'd0, 64'd100, 64'd23, 64'd123, 1'b0, 4'd5},                   // R5
        '{4'd3,  2'd0, 64'd3, 64'd10, 64'd0, 1'b1, 4'd5},                       // R5
        '{4'd3,  2'd0, 64'd10, 64'd3, 64'd7, 1'b0, 4'd5},                       // R5
        '{4'd4,  2'd0, SMIN, 64'd0, SMAX, 1'b1, 4'd6},                          // R6
        '{4'd4,  2'd0, 64'hFFFF_FFFF_FFFF_FFFB, 64'd0, 64'd5, 1'b0, 4'd6},      // R6
        '{4'd5,  2'd0, SMIN, 64'd0, SMAX, 1'b1, 4'd6},                          // R6
        '{4'd5,  2'd0, 64'd5, 64'd0, 64'hFFFF_FFFF_FFFF_FFFB, 1'b0, 4'd6},      // R6
        '{4'd6,  2'd0, 64'd200, 64'd0, 64'h7F, 1'b1, 4'd2},                     // R2
        '{4'd6,  2'd0, 64'hFFFF_FFFF_FFFF_FF38, 64'd0,
                       64'hFFFF_FFFF_FFFF_FF80, 1'b1, 4'd2},                    // R2
        '{4'd6,  2'd1, 64'hFFFF_FFFF_FFFF_FFFB, 64'd0,
                       64'hFFFF_FFFF_FFFF_FFFB, 1'b0, 4'd2},                    // R2
        '{4'd7,  2'd0, ONES, 64'd0, 64'd0, 1'b1, 4'd2},                         // R2
        '{4'd7,  2'd1, 64'd70000, 64'd0, 64'hFFFF, 1'b1, 4'd1},                 // R1
        '{4'd7,  2'd2, 64'h1234, 64'd0, 64'h1234, 1'b0, 4'd1},                  // R1
        '{4'd8,  2'd2, 64'hFFFF_FFFF, 64'd0, 64'h7FFF_FFFF, 1'b1, 4'd1},        // R1
        '{4'd9,  2'd0, 64'h100, 64'd0, 64'hFF, 1'b1, 4'd2},                     // R2
        '{4'd6,  2'd3, SMIN, 64'd0, SMIN, 1'b0, 4'd1},                          // R1
        '{4'd8,  2'd3, ONES, 64'd0, SMAX, 1'b1, 4'd1},                          // R1
        '{4'd10, 2'd0, 64'd5, 64'hFFFF_FFFF_FFFF_FFFD, 64'd2, 1'b0, 4'd7},      // R7
        '{4'd10, 2'd0, SMAX, 64'd1, SMAX, 1'b1, 4'd7},                          // R7
        '{4'd10, 2'd0, SMIN, 64'd0, SMAX, 1'b1, 4'd7},                          // R7
        '{4'd10, 2'd0, 64'h8000_0000_0000_0005, 64'hFFFF_FFFF_FFFF_FFF6,
                       64'h7FFF_FFFF_FFFF_FFFB, 1'b0, 4'd7},                    // R7
        '{4'd10, 2'd0, ONES, ONES, SMAX, 1'b1, 4'd7},                           // R7
        '{4'd11, 2'd0, 64'd5, 64'd7, 64'd12, 1'b0, 4'd8},                       // R8
        '{4'd11, 2'd0, 64'd1, ONES, ONES, 1'b1, 4'd8},                          // R8
        '{4'd11, 2'd0, ONES, SMIN, SMAX, 1'b0, 4'd8},                           // R8
        '{4'd11, 2'd0, 64'hFFFF_FFFF_FFFF_FFF6, 64'd3, 64'd0, 1'b1, 4'd8},      // R8
        '{4'd11, 2'd0, 64'hFFFF_FFFF_FFFF_FFFD, 64'd10, 64'd7, 1'b0, 4'd8},     // R8
        '{4'd15, 2'd0, SMAX, 64'd1, 64'd0, 1'b0, 4'd13}                         // R13
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [3:0]  op = '0;
    logic [1:0]  elem_size = '0;
    logic [63:0] opa = '0;
    logic [63:0] opb = '0;
    logic        sat_clr = 1'b0;
    logic        out_valid;
    logic [63:0] out_result;
    logic        sat_flag;

    int n_checks = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    sat_alu u_dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .in_valid   (in_valid),
        .op         (op),
        .elem_size  (elem_size),
        .opa        (opa),
        .opb        (opb),
        .sat_clr    (sat_clr),
        .out_valid  (out_valid),
        .out_result (out_result),
        .sat_flag   (sat_flag)
    );

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Present one cycle of stimulus, then sample at the following negedge.
    task automatic step(input logic v, input logic [3:0] o, input logic [1:0] s,
                        input logic [63:0] a, input logic [63:0] b, input logic c);
        @(negedge clk);
        in_valid  = v;
        op        = o;
        elem_size = s;
        opa       = a;
        opb       = b;
        sat_clr   = c;
        @(posedge clk);
        #1;
        in_valid = 1'b0;
        sat_clr  = 1'b0;
        @(negedge clk);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R12: reset state
        chk("R12 out_valid", 64'(out_valid), 64'd0);
        chk("R12 out_result", out_result, 64'd0);
        chk("R12 sat_flag", 64'(sat_flag), 64'd0);
        rst_n = 1'b1;
        @(negedge clk);

        // Table walk: clear strobe rides along with every vector (R10 overlap).
        for (int i = 0; i < NVEC; i++) begin
            step(1'b1, VECS[i].op, VECS[i].size, VECS[i].a, VECS[i].b, 1'b1);
            chk($sformatf("R%0d result vec %0d", VECS[i].req, i), out_result, VECS[i].exp);
            chk($sformatf("R%0d flag vec %0d (R10 clear overlap)", VECS[i].req, i),
                64'(sat_flag), 64'(VECS[i].sat));
            chk($sformatf("R11 out_valid vec %0d", i), 64'(out_valid), 64'd1);
        end

        // R9: flag survives a later non-clamping operation
        step(1'b1, 4'd0, 2'd0, SMAX, 64'd1, 1'b1);
        chk("R9 set", 64'(sat_flag), 64'd1);
        step(1'b1, 4'd0, 2'd0, 64'd1, 64'd1, 1'b0);
        chk("R9 result", out_result, 64'd2);
        chk("R9 sticky", 64'(sat_flag), 64'd1);

        // R11: idle cycle drops valid and holds result
        @(negedge clk);
        chk("R11 idle valid", 64'(out_valid), 64'd0);
        chk("R11 idle hold", out_result, 64'd2);

        // R10: clear with no operation
        step(1'b0, 4'd0, 2'd0, 64'd0, 64'd0, 1'b1);
        chk("R10 clear alone", 64'(sat_flag), 64'd0);

        // R11: clamping operands with in_valid low are ignored
        step(1'b0, 4'd1, 2'd0, ONES, ONES, 1'b0);
        chk("R11 ignored flag", 64'(sat_flag), 64'd0);
        chk("R11 ignored result", out_result, 64'd2);
        chk("R11 ignored valid", 64'(out_valid), 64'd0);

        // R13: unknown opcode does not set the flag
        step(1'b1, 4'd12, 2'd0, ONES, ONES, 1'b0);
        chk("R13 result", out_result, 64'd0);
        chk("R13 flag", 64'(sat_flag), 64'd0);

        // R10: clamp without clear, then clear together with a clamp
        step(1'b1, 4'd3, 2'd0, 64'd0, 64'd1, 1'b0);
        chk("R10 clamp sets", 64'(sat_flag), 64'd1);
        step(1'b1, 4'd5, 2'd0, SMIN, 64'd0, 1'b1);
        chk("R10 set wins", 64'(sat_flag), 64'd1);
        chk("R6 neg min", out_result, SMAX);

        // R12: reset mid-run clears everything
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        chk("R12 re-reset flag", 64'(sat_flag), 64'd0);
        chk("R12 re-reset result", out_result, 64'd0);

        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule